// File: doc/BRIEF.md
# Key-Protected System Control Register

A single 32-bit control and status register that sits on a plain register bus (select, write enable, address, write data, combinational read data). It holds a 3-bit interrupt priority grouping value for the interrupt controller, reports the data endianness latched from a configuration pin while reset is held, and emits single-cycle request pulses: one toward the system reset controller and two auxiliary control strobes.

A write takes effect only when its upper halfword carries the unlock key 0x05FA. Any other write is dropped in full. The upper halfword always reads back as the byte-swapped signature 0xFA05. The three strobe bits are write-only and clear themselves. The register's own reset input is separate from the reset it requests. An asserted request pulse clears nothing locally. Only the controller's later assertion of `rst_ni` does that, so debug-side logic on the same clock is left untouched.

Top module: `sysctl_keyed_reg`

## Requirements
- R1: A write (sel_i=1, we_i=1, addr_i equal to REG_ADDR) is accepted only when wdata_i[31:16] equals 0x05FA.
- R2: A write with any other key value changes no stored field and produces no pulse on sys_rst_req_o or aux_pulse_o.
- R3: A read of the register returns 0xFA05 in rdata_o[31:16], whatever was last written.
- R4: rdata_o[15] holds the value of big_endian_i sampled on each rising clock edge while rst_ni is low (1 = big-endian, 0 = little-endian). It is never changed by writes.
- R5: The grouping field at bits 10:8 is read/write, drives prigroup_o, and is 0 after rst_ni.
- R6: An accepted write with wdata_i[2]=1 makes sys_rst_req_o high for exactly one cycle, in the cycle after the write edge. Writing 0 to that bit has no effect.
- R7: The accepted write bits 1 and 0 pulse aux_pulse_o[1] and aux_pulse_o[0] with the same one-cycle timing. Bits 2:0 always read 0.
- R8: Reserved bits 14:11 and 7:3 always read 0.
- R9: When sel_i=0 or addr_i differs from REG_ADDR, rdata_o is 0 and a write changes nothing.
- R10: The grouping field keeps its value across its own reset-request pulse. Only rst_ni clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset for the register |
| big_endian_i | input | 1 | Endianness configuration, sampled while in reset |
| sel_i | input | 1 | Bus select |
| we_i | input | 1 | Bus write enable |
| addr_i | input | AW | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data (combinational) |
| prigroup_o | output | 3 | Priority grouping value to the interrupt controller |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| aux_pulse_o | output | 2 | One-cycle auxiliary control strobes |

## Verification
The assertions assume that bus inputs are stable across each rising edge. They also assume that big_endian_i matters only while rst_ni is low, and that rst_ni is held low for at least one clock edge so the endianness bit is defined. The bench drives every input on the falling edge and holds reset low for several cycles. It changes big_endian_i only between reset pulses. Random writes mix valid and corrupted keys with matching and non-matching addresses, so both the accept path and the reject path are checked against a bench-side model.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DW        = 32;
  localparam logic [15:0] UNLOCK_KEY = 16'h05FA;
  localparam logic [15:0] READ_SIG   = 16'hFA05;
  localparam int unsigned END_BIT   = 15;
  localparam int unsigned GRP_LSB   = 8;
  localparam int unsigned GRP_W     = 3;
  localparam int unsigned NPULSE    = 3;   // bits 2:0
  localparam int unsigned REQ_BIT   = 2;
endpackage

// File: rtl/sysctl_key_check.sv
module sysctl_key_check #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] REG_ADDR = '0
) (
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   key_i,
  output logic          hit_o,
  output logic          wr_ok_o
);
  import sysctl_pkg::*;
  assign hit_o   = sel_i && (addr_i == REG_ADDR);
  assign wr_ok_o = hit_o && we_i && (key_i == UNLOCK_KEY);
endmodule

// File: rtl/sysctl_fields.sv
module sysctl_fields #(
  parameter int unsigned GW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          big_endian_i,
  input  logic          wr_ok_i,
  input  logic [GW-1:0] grp_wdata_i,
  output logic [GW-1:0] grp_o,
  output logic          endian_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      grp_o <= '0;
    else if (wr_ok_i) grp_o <= grp_wdata_i;
  end

  // captured only while reset is held; writes never reach it
  always_ff @(posedge clk_i) begin
    if (!rst_ni) endian_o <= big_endian_i;
  end

  AST_GRP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_i |=> $stable(grp_o)); // R2
  AST_ENDIAN_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(endian_o)); // R4
endmodule

// File: rtl/sysctl_pulse_gen.sv
module sysctl_pulse_gen #(
  parameter int unsigned NP = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ok_i,
  input  logic [NP-1:0] bits_i,
  output logic [NP-1:0] pulse_o
);
  for (genvar i = 0; i < NP; i++) begin : g_pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_o[i] <= 1'b0;
      else         pulse_o[i] <= wr_ok_i && bits_i[i];
    end
    AST_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_ok_i |=> !pulse_o[i]); // R2
  end
endmodule

// File: rtl/sysctl_keyed_reg.sv
module sysctl_keyed_reg
  import sysctl_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h0C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          big_endian_i,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic [2:0]    prigroup_o,
  output logic          sys_rst_req_o,
  output logic [1:0]    aux_pulse_o
);
  logic hit, wr_ok, endian;
  logic [GRP_W-1:0]  grp;
  logic [NPULSE-1:0] pulses;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[15:11], wdata_i[7:3]};

  sysctl_key_check #(.AW(AW), .REG_ADDR(REG_ADDR)) u_key (
    .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i), .key_i(wdata_i[31:16]),
    .hit_o(hit), .wr_ok_o(wr_ok)
  );

  sysctl_fields #(.GW(GRP_W)) u_fields (
    .clk_i(clk_i), .rst_ni(rst_ni), .big_endian_i(big_endian_i),
    .wr_ok_i(wr_ok), .grp_wdata_i(wdata_i[GRP_LSB +: GRP_W]),
    .grp_o(grp), .endian_o(endian)
  );

  sysctl_pulse_gen #(.NP(NPULSE)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ok_i(wr_ok),
    .bits_i(wdata_i[NPULSE-1:0]), .pulse_o(pulses)
  );

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[31:16]                = READ_SIG;
      rdata_o[END_BIT]              = endian;
      rdata_o[GRP_LSB +: GRP_W]     = grp;
    end
  end

  assign prigroup_o    = grp;
  assign sys_rst_req_o = pulses[REQ_BIT];
  assign aux_pulse_o   = pulses[1:0];

  AST_KEY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> $past(sel_i && we_i && addr_i == REG_ADDR
                            && wdata_i[31:16] == 16'h05FA && wdata_i[2])); // R1
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_req_o && !(sel_i && we_i && addr_i == REG_ADDR && wdata_i[31:16] == 16'h05FA))
    |=> !sys_rst_req_o); // R6
  AST_SIG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && addr_i == REG_ADDR) |-> rdata_o[31:16] == 16'hFA05); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[14:11] == 4'h0 && rdata_o[7:0] == 8'h00); // R8
  AST_GRP_SURVIVES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_req_o && !we_i) |=> $stable(prigroup_o)); // R10
  AST_NOSEL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> rdata_o == 32'h0); // R9
endmodule

// File: tb/tb_sysctl_keyed_reg.sv
`timescale 1ns/1ps
module tb_sysctl_keyed_reg;
  localparam logic [7:0] RA = 8'h0C;

  logic clk = 0, rst_ni = 0, big_endian = 1;
  logic sel = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  grp_o;
  logic        req_o;
  logic [1:0]  aux_o;

  int checks = 0, fails = 0;
  logic [2:0] m_grp;
  logic       m_end;

  always #2.5 clk = ~clk;

  sysctl_keyed_reg dut (
    .clk_i(clk), .rst_ni(rst_ni), .big_endian_i(big_endian),
    .sel_i(sel), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .prigroup_o(grp_o), .sys_rst_req_o(req_o), .aux_pulse_o(aux_o)
  );

  function automatic logic [31:0] exp_rd(logic [2:0] g, logic e);
    return {16'hFA05, e, 4'b0, g, 8'h00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic be);
    @(negedge clk);
    big_endian = be; rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    m_grp = 0; m_end = be;
  endtask

  // drive at negedge, registered pulses checked at the next negedge
  task automatic wr(logic [7:0] a, logic [31:0] d, logic s);
    logic ok;
    @(negedge clk);
    sel = s; we = 1; addr = a; wdata = d;
    ok = s && a == RA && d[31:16] == 16'h05FA;
    @(negedge clk);
    sel = 0; we = 0; wdata = '0;
    chk("R6", {31'b0, req_o}, {31'b0, ok & d[2]});
    chk("R7", {30'b0, aux_o}, {30'b0, ok ? d[1:0] : 2'b00});
    if (ok) m_grp = d[10:8];
    else    chk("R2", {29'b0, grp_o}, {29'b0, m_grp});
    @(negedge clk);
    chk("R6 self-clear", {29'b0, req_o, aux_o}, 32'h0);
  endtask

  task automatic rd_chk(string req);
    sel = 1; we = 0; addr = RA;
    #1;
    chk(req, rdata, exp_rd(m_grp, m_end));
    chk("R5", {29'b0, grp_o}, {29'b0, m_grp});
    sel = 0;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(1'b1);
    @(negedge clk);
    rd_chk("R4 R5 reset big-endian");
    chk("R6 reset", {30'b0, req_o, 1'b0}, 32'h0);

    // R1: valid write, fields stored, strobes pulse
    wr(RA, 32'h05FA_0507, 1);
    @(negedge clk); rd_chk("R1 R3 R7 R8");
    // R2: bad key, all ones data
    wr(RA, 32'h05FB_FFFF, 1);
    @(negedge clk); rd_chk("R2");
    wr(RA, 32'hFA05_0607, 1);
    @(negedge clk); rd_chk("R2 swapped key");
    // R9: wrong address and not selected
    wr(8'h10, 32'h05FA_0307, 1);
    wr(RA, 32'h05FA_0307, 0);
    @(negedge clk); rd_chk("R9 write ignored");
    @(negedge clk); sel = 1; addr = 8'h10; #1;
    chk("R9 other addr reads 0", rdata, 32'h0); sel = 0;
    // R4: endianness bit cannot be written
    wr(RA, 32'h05FA_0000, 1);
    @(negedge clk); rd_chk("R4 write-protect");
    // R10: request pulse leaves grouping intact
    wr(RA, 32'h05FA_0604, 1);
    repeat (3) @(negedge clk);
    rd_chk("R10");
    // R6: writing 0 has no effect
    wr(RA, 32'h05FA_0600, 1);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom_range(0, 1) == 0) d[31:16] = 16'h05FA;
      wr(($urandom_range(0, 3) == 0) ? 8'h08 : RA, d, $urandom_range(0, 7) != 0);
      @(negedge clk); rd_chk("R1 R3 R8 random");
    end

    // R4/R5: re-reset little-endian clears grouping
    wr(RA, 32'h05FA_0500, 1);
    do_reset(1'b0);
    @(negedge clk);
    big_endian = 1;
    @(negedge clk);
    rd_chk("R4 R5 little-endian reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule